// File: doc/BRIEF.md
# Masked-Access GPIO Port with Interrupt Detection

This block is an eight-line general-purpose I/O port on a simple memory-mapped bus with byte-wide registers. Each line is an input or an output. A data window covers the bottom of the address map. In that window, word-address bits [9:2] act as a line mask, so software can read or drive any subset of lines in one access. It needs no read-modify-write.

Every line has its own interrupt detector. A line can sense a high or low level, a rising or falling edge, or both edges. Edge events are latched until software clears them. Level events follow the pin. A per-line enable gates the raw status into a masked status, and a single interrupt output is the OR of the masked bits.

Pin inputs are resynchronised by two flops before they are read or detected. Constant identification bytes sit at the top of the map.

Top module: `maskgpio`

## Requirements
- R1: After reset, pad_oe is 0, irq_out is 0, and the direction (0x400), sense (0x404), both-edge (0x408), polarity (0x40C) and enable (0x410) registers all read 0.
- R2: Direction bit n = 1 makes line n an output: pad_oe[n] follows direction bit n, and pad_out[n] carries the line's data value.
- R3: A read at window address (m << 2) returns, for each line n with m[n] = 1, the driven value if the line is an output and the synchronised pin if it is an input. Lines with m[n] = 0 read 0.
- R4: A write at window address (m << 2) updates only output lines with m[n] = 1. A write to a line that is an input is ignored: after that line is switched to output, it still drives its old value.
- R5: With sense bit = 1 (level), raw status (0x414) is the synchronised pin when polarity = 1 and its inverse when polarity = 0. It is not latched, and a clear does not change it.
- R6: With sense = 0 and both-edge = 0, a rising edge (polarity = 1) or a falling edge (polarity = 0) sets a latched raw status bit. The opposite edge does not set it.
- R7: With sense = 0 and both-edge = 1, either edge sets the raw status bit, whatever the polarity bit holds.
- R8: Masked status (0x418) is raw status ANDed with the enable register, and irq_out = 1 exactly when any masked bit is 1.
- R9: Writing to the clear register (0x41C) clears the latched edge status of the lines whose written bit is 1. Other lines are unchanged, and the register reads 0.
- R10: If an edge event and a clear hit the same line in the same cycle, the status bit stays set.
- R11: The bytes at 0xFE0, 0xFE4, 0xFE8 and 0xFEC read 0x61, 0x10, 0x04 and 0x00.
- R12: A pin change reaches the level-mode raw status after exactly two rising clock edges, and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pad_in | input | 8 | Pin inputs, asynchronous |
| pad_out | output | 8 | Pin output values |
| pad_oe | output | 8 | Pin output enables |
| irq_out | output | 1 | Combined interrupt |

## Verification
The collision that matters is an edge event meeting a software clear on the same line in the same cycle. The bench provokes it by changing a pin, waiting exactly the two synchroniser edges, and landing a clear write in the cycle where the detector fires. It then judges the outcome by reading raw status: the bit must stay set. A second clear one cycle later must empty it. A second overlap is a data-window write meeting a direction change. It is judged by writing to input lines and then switching them to output and watching pad_out.

// File: rtl/mgp_pkg.sv
package mgp_pkg;
  localparam int GP_W  = 8;
  localparam int GP_AW = 12;

  typedef logic [GP_W-1:0] gp_vec_t;

  localparam logic [GP_AW-1:0] OFF_DIR   = 12'h400;
  localparam logic [GP_AW-1:0] OFF_SENSE = 12'h404;
  localparam logic [GP_AW-1:0] OFF_BOTH  = 12'h408;
  localparam logic [GP_AW-1:0] OFF_POL   = 12'h40C;
  localparam logic [GP_AW-1:0] OFF_IE    = 12'h410;
  localparam logic [GP_AW-1:0] OFF_RAW   = 12'h414;
  localparam logic [GP_AW-1:0] OFF_MIS   = 12'h418;
  localparam logic [GP_AW-1:0] OFF_CLR   = 12'h41C;
  localparam logic [GP_AW-5:0] ID_PAGE   = 8'hFE;
  localparam logic [31:0]      GP_IDENT  = 32'h0004_1061;

  function automatic gp_vec_t window_read(gp_vec_t mask, gp_vec_t value);
    return mask & value;
  endfunction

  function automatic gp_vec_t window_merge(gp_vec_t old, gp_vec_t wdata,
                                           gp_vec_t mask, gp_vec_t dir);
    gp_vec_t upd;
    upd = mask & dir;
    return (old & ~upd) | (wdata & upd);
  endfunction

  function automatic gp_vec_t edge_event(gp_vec_t cur, gp_vec_t prev,
                                         gp_vec_t both, gp_vec_t pol);
    gp_vec_t rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    return (both & (rise | fall)) | (~both & ((pol & rise) | (~pol & fall)));
  endfunction

  function automatic gp_vec_t level_event(gp_vec_t cur, gp_vec_t pol);
    return ~(cur ^ pol);
  endfunction

  function automatic logic [7:0] id_byte(logic [1:0] idx);
    return 8'(GP_IDENT >> (8 * idx));
  endfunction
endpackage

// File: rtl/mgp_sync.sv
module mgp_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/mgp_detect.sv
module mgp_detect
  import mgp_pkg::*;
#(
  parameter int W = GP_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  gp_vec_t      cur,
  input  gp_vec_t      sense,
  input  gp_vec_t      both,
  input  gp_vec_t      pol,
  input  gp_vec_t      clr,
  output gp_vec_t      raw,
  output gp_vec_t      edge_evt,
  output gp_vec_t      latch_q
);
  gp_vec_t prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  assign edge_evt = edge_event(cur, prev_q, both, pol);

  for (genvar i = 0; i < W; i++) begin : g_line
    // a new event outranks a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latch_q[i] <= 1'b0;
      else        latch_q[i] <= edge_evt[i] | (latch_q[i] & ~clr[i]);
    end
  end

  assign raw = (sense & level_event(cur, pol)) | (~sense & latch_q);
endmodule

// File: rtl/maskgpio.sv
module maskgpio
  import mgp_pkg::*;
#(
  parameter int ADDR_W = GP_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        pad_in,
  output logic [7:0]        pad_out,
  output logic [7:0]        pad_oe,
  output logic              irq_out
);
  localparam int MASK_LO = 2;
  localparam int MASK_HI = MASK_LO + GP_W - 1;

  gp_vec_t dir_q, sense_q, both_q, pol_q, ie_q, out_q;
  gp_vec_t pin_s, raw, mis, edge_evt, latch_q, clr_vec, win_mask, line_val;
  logic    aligned, in_window, in_id, wr_stb;

  mgp_sync #(.W(GP_W)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_s)
  );

  mgp_detect #(.W(GP_W)) det_i (
    .clk(clk), .rst_n(rst_n), .cur(pin_s), .sense(sense_q), .both(both_q),
    .pol(pol_q), .clr(clr_vec), .raw(raw), .edge_evt(edge_evt), .latch_q(latch_q)
  );

  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign in_window = aligned && (bus_addr[ADDR_W-1:MASK_HI+1] == '0);
  assign in_id     = aligned && (bus_addr[ADDR_W-1:4] == ID_PAGE);
  assign win_mask  = bus_addr[MASK_HI:MASK_LO];
  assign wr_stb    = bus_sel && bus_wr;
  assign clr_vec   = (wr_stb && bus_addr == OFF_CLR) ? bus_wdata : '0;
  assign line_val  = (dir_q & out_q) | (~dir_q & pin_s);
  assign mis       = raw & ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      ie_q    <= '0;
      out_q   <= '0;
    end else if (wr_stb) begin
      if (in_window)             out_q   <= window_merge(out_q, bus_wdata, win_mask, dir_q);
      if (bus_addr == OFF_DIR)   dir_q   <= bus_wdata;
      if (bus_addr == OFF_SENSE) sense_q <= bus_wdata;
      if (bus_addr == OFF_BOTH)  both_q  <= bus_wdata;
      if (bus_addr == OFF_POL)   pol_q   <= bus_wdata;
      if (bus_addr == OFF_IE)    ie_q    <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_window)                  bus_rdata = window_read(win_mask, line_val);
    else if (in_id)                 bus_rdata = id_byte(bus_addr[3:2]);
    else if (bus_addr == OFF_DIR)   bus_rdata = dir_q;
    else if (bus_addr == OFF_SENSE) bus_rdata = sense_q;
    else if (bus_addr == OFF_BOTH)  bus_rdata = both_q;
    else if (bus_addr == OFF_POL)   bus_rdata = pol_q;
    else if (bus_addr == OFF_IE)    bus_rdata = ie_q;
    else if (bus_addr == OFF_RAW)   bus_rdata = raw;
    else if (bus_addr == OFF_MIS)   bus_rdata = mis;
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
  assign irq_out = |mis;
endmodule

// File: rtl/maskgpio_chk.sv
module maskgpio_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic [7:0]        pad_out,
  input logic [7:0]        pad_oe,
  input logic              irq_out,
  input logic [7:0]        ie_q,
  input logic [7:0]        edge_evt,
  input logic [7:0]        clr_vec,
  input logic [7:0]        latch_q
);
  AST_WINDOW_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[ADDR_W-1:10] == '0 && bus_addr[1:0] == 2'b00)
      |-> ((bus_rdata & ~bus_addr[9:2]) == 8'h00)); // R3

  AST_INPUT_LINE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out ^ $past(pad_out)) & ~$past(pad_oe)) == 8'h00); // R4

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt != 8'h00) |=> ((latch_q & $past(edge_evt)) == $past(edge_evt))); // R6

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (ie_q != 8'h00)); // R8

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~edge_evt) != 8'h00) |=> ((latch_q & $past(clr_vec & ~edge_evt)) == 8'h00)); // R9

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & edge_evt) != 8'h00)
      |=> ((latch_q & $past(clr_vec & edge_evt)) == $past(clr_vec & edge_evt))); // R10
endmodule

bind maskgpio maskgpio_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .pad_out(pad_out),
  .pad_oe(pad_oe), .irq_out(irq_out), .ie_q(ie_q), .edge_evt(edge_evt),
  .clr_vec(clr_vec), .latch_q(latch_q)
);

// File: tb/maskgpio_tb_top.sv
module maskgpio_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_DIR = 12'h400, A_SENSE = 12'h404, A_BOTH = 12'h408,
                          A_POL = 12'h40C, A_IE = 12'h410, A_RAW = 12'h414,
                          A_MIS = 12'h418, A_CLR = 12'h41C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata, pad_in = '0, pad_out, pad_oe;
  logic        irq_out;
  int          n_checks = 0, n_errors = 0;

  maskgpio dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] rd, out_exp, dir;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 irq", {7'd0, irq_out}, 8'h00);
    bus_read(A_DIR, rd);   check("R1 dir", rd, 8'h00);
    bus_read(A_SENSE, rd); check("R1 sense", rd, 8'h00);
    bus_read(A_BOTH, rd);  check("R1 both", rd, 8'h00);
    bus_read(A_POL, rd);   check("R1 pol", rd, 8'h00);
    bus_read(A_IE, rd);    check("R1 ie", rd, 8'h00);
    bus_read(A_CLR, rd);   check("R9 clear reads zero", rd, 8'h00);

    // R11 identification
    for (int i = 0; i < 4; i++) begin
      bus_read(12'hFE0 + 12'(4 * i), rd);
      check("R11 id byte", rd, 8'(32'h0004_1061 >> (8 * i)));
    end

    // R2, R3, R4 data window sweep
    dir = 8'hA5;
    bus_write(A_DIR, dir);
    #1 check("R2 pad_oe follows dir", pad_oe, dir);
    @(negedge clk); pad_in = 8'h5A;
    settle();
    out_exp = 8'h00;
    for (int m = 0; m < 256; m++) begin
      logic [7:0] wd;
      wd = 8'(m) ^ 8'hC3 ^ 8'(m << 3);
      bus_write(12'(m << 2), wd);
      out_exp = (out_exp & ~(8'(m) & dir)) | (wd & 8'(m) & dir);
      #1 check("R4 masked write", pad_out, out_exp);
      bus_read(12'(m << 2), rd);
      check("R3 masked read", rd, 8'(m) & ((dir & out_exp) | (~dir & 8'h5A)));
    end

    // R4 write to input lines ignored
    bus_write(A_DIR, 8'h00);
    bus_write(12'h3FC, ~out_exp);
    bus_write(A_DIR, 8'hFF);
    #1 check("R4 input write ignored", pad_out, out_exp);
    check("R2 all outputs", pad_oe, 8'hFF);
    bus_write(12'h3FC, 8'h3C);
    #1 check("R2 pad_out driven", pad_out, 8'h3C);
    bus_write(A_DIR, 8'h00);
    @(negedge clk); pad_in = 8'h00;
    settle();

    // R12 synchroniser latency, level high on line 0
    bus_write(A_SENSE, 8'h01);
    bus_write(A_POL, 8'h01);
    @(negedge clk); pad_in = 8'h01;
    bus_read(A_RAW, rd); check("R12 one edge", rd & 8'h01, 8'h00);
    bus_read(A_RAW, rd); check("R12 two edges", rd & 8'h01, 8'h01);
    @(negedge clk); pad_in = 8'h00;
    settle();

    // R5, R6, R7, R8 mode sweep over every line
    bus_write(A_IE, 8'hFF);
    for (int n = 0; n < 8; n++) begin
      for (int mode = 0; mode < 5; mode++) begin
        logic lat, pin, ex;
        logic [7:0] bit_n;
        string tag;
        bit_n = 8'(1 << n);
        tag = (mode < 2) ? "R5 level" : (mode < 4) ? "R6 edge" : "R7 both";
        bus_write(A_SENSE, (mode < 2) ? bit_n : 8'h00);
        bus_write(A_POL, (mode == 0 || mode == 2) ? bit_n : 8'h00);
        bus_write(A_BOTH, (mode == 4) ? bit_n : 8'h00);
        bus_write(A_CLR, 8'hFF);
        lat = 1'b0; pin = 1'b0;
        for (int step = 0; step < 4; step++) begin
          if (step == 1) begin
            @(negedge clk); pad_in = bit_n; pin = 1'b1;
            if (mode == 2 || mode == 4) lat = 1'b1;
          end else if (step == 2) begin
            bus_write(A_CLR, 8'hFF); lat = 1'b0;
          end else if (step == 3) begin
            @(negedge clk); pad_in = 8'h00; pin = 1'b0;
            if (mode == 3 || mode == 4) lat = 1'b1;
          end
          settle();
          ex = (mode == 0) ? pin : (mode == 1) ? ~pin : lat;
          bus_read(A_RAW, rd); check(tag, rd, ex ? bit_n : 8'h00);
          bus_read(A_MIS, rd); check("R8 masked", rd, ex ? bit_n : 8'h00);
          check("R8 irq", {7'd0, irq_out}, {7'd0, ex});
        end
      end
    end

    // R8 enable gating
    bus_write(A_SENSE, 8'h00); bus_write(A_BOTH, 8'h00); bus_write(A_POL, 8'hFF);
    bus_write(A_IE, 8'h00);
    bus_write(A_CLR, 8'hFF);
    @(negedge clk); pad_in = 8'h08;
    settle();
    bus_read(A_RAW, rd); check("R8 raw with enable off", rd, 8'h08);
    bus_read(A_MIS, rd); check("R8 masked with enable off", rd, 8'h00);
    check("R8 irq off", {7'd0, irq_out}, 8'h00);
    bus_write(A_IE, 8'h08);
    #1 check("R8 irq on", {7'd0, irq_out}, 8'h01);
    bus_write(A_IE, 8'hF7);
    #1 check("R8 irq other enables", {7'd0, irq_out}, 8'h00);
    bus_write(A_IE, 8'hFF);

    // R9 partial clear
    @(negedge clk); pad_in = 8'h0E;
    settle();
    bus_read(A_RAW, rd); check("R9 before clear", rd, 8'h0E);
    bus_write(A_CLR, 8'h02);
    bus_read(A_RAW, rd); check("R9 partial clear", rd, 8'h0C);
    bus_write(A_CLR, 8'h00);
    bus_read(A_RAW, rd); check("R9 zero clear", rd, 8'h0C);
    bus_write(A_CLR, 8'hFF);
    bus_read(A_RAW, rd); check("R9 full clear", rd, 8'h00);

    // R10 event and clear in the same cycle on line 5
    @(negedge clk); pad_in = 8'h2E;
    @(negedge clk);
    bus_write(A_CLR, 8'h20);
    bus_read(A_RAW, rd); check("R10 event wins", rd, 8'h20);
    bus_write(A_CLR, 8'h20);
    bus_read(A_RAW, rd); check("R10 later clear", rd, 8'h00);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule